// File: doc/BRIEF.md
# Power-Mode Clock Request Gating

This block decides, cycle by cycle, whether each of three system clocks (auxiliary, main and sub-main) may run. The decision combines a 3-bit power-mode code, a force-off control for the sub-main clock, a request-enable bit per clock and a live request line per clock. For each clock the block drives a registered enable and a gated copy of that clock. The gated copy comes from a cell that samples the enable in a latch that is open only while the source clock is low. As a result the gated output never starts or ends a high phase part-way through.

A peripheral that needs a clock during a low-power mode raises its request line. That line is asynchronous, so each one is resynchronised in the domain of the clock it asks for before it can affect the decision. The power-mode and control inputs are captured by a separate control clock. All four clocks are assumed to be synchronous to one another. A request-enable bit only matters in a mode where its clock would otherwise be stopped. In the two retention modes all three clocks are stopped whatever the other inputs say.

Top module: `pcg_top`

## Requirements
- R1: While `rst` is high, every bit of `clk_en` is 0 and every bit of `clk_gated` stays low.
- R2: Power-mode codes are 0 = active, 1..5 = low-power 0..4, 6 and 7 = the two retention modes. In codes 6 and 7 all three enables are 0 regardless of `sub_force_off`, `req_en` and `req`.
- R3: Main clock (bit 1 of every per-clock vector) runs in code 0. In codes 1..5 it runs only when `req_en[1]` and a synchronised `req[1]` are both 1.
- R4: Auxiliary clock (bit 0) runs in codes 0..4. In code 5 it runs only when `req_en[0]` and a synchronised `req[0]` are both 1.
- R5: With `sub_force_off` = 0, the sub-main clock (bit 2) runs in codes 0..2. In codes 3..5 it runs only when `req_en[2]` and a synchronised `req[2]` are both 1.
- R6: With `sub_force_off` = 1, the sub-main clock runs in codes 0..5 only when `req_en[2]` and a synchronised `req[2]` are both 1.
- R7: A change on a `req` bit reaches the matching `clk_en` bit on the third rising edge of that clock after the change, and not before.
- R8: Each `clk_gated` bit is low whenever its source clock is low. During a high phase it equals the enable value held before that phase's rising edge, so a new enable shows on the gated clock one full cycle after it appears on `clk_en`.
- R9: A change on `pwr_mode`, `sub_force_off` or `req_en` reaches `clk_en` on the second rising edge after the change, and not on the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ctl | input | 1 | Control clock that captures mode and enable inputs |
| rst | input | 1 | Synchronous active-high reset, applied in every domain |
| clk_src | input | 3 | Source clocks: bit 0 auxiliary, bit 1 main, bit 2 sub-main |
| pwr_mode | input | 3 | Power-mode code (see R2) |
| sub_force_off | input | 1 | Keeps the sub-main clock stopped unless it is requested |
| req_en | input | 3 | Per-clock request-enable |
| req | input | 3 | Per-clock asynchronous clock request |
| clk_en | output | 3 | Registered per-clock run enable |
| clk_gated | output | 3 | Glitch-free gated clocks |

## Verification
On every cycle the assertions check the mode rules against the captured configuration and the synchronised requests. They cover retention forcing all enables off, the main and auxiliary clocks running in their always-on modes, the sub-main always-on window, and no main enable while in low power without a synchronised request. Only the bench scenarios show the cycle counts through the synchronisers and the capture register, the one-cycle lag of the gated clock behind its enable, and the full table of mode, force-off, enable and request combinations seen at the ports.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    localparam int NUM_CLK  = 3;
    localparam int CK_AUX   = 0;
    localparam int CK_MAIN  = 1;
    localparam int CK_SUB   = 2;
    localparam int MODE_W   = 3;

    typedef enum logic [MODE_W-1:0] {
        PM_ACTIVE = 3'd0,
        PM_LP0    = 3'd1,
        PM_LP1    = 3'd2,
        PM_LP2    = 3'd3,
        PM_LP3    = 3'd4,
        PM_LP4    = 3'd5,
        PM_RET_A  = 3'd6,
        PM_RET_B  = 3'd7
    } pwr_mode_e;

    typedef struct packed {
        pwr_mode_e            mode;
        logic                 sub_off;
        logic [NUM_CLK-1:0]   req_en;
    } gate_cfg_t;

    function automatic logic is_retention(pwr_mode_e m);
        return (m == PM_RET_A) || (m == PM_RET_B);
    endfunction

    // Whether a clock runs in this mode with no request at all.
    function automatic logic runs_unrequested(pwr_mode_e m, logic sub_off, int idx);
        logic r;
        r = 1'b0;
        case (idx)
            CK_MAIN: r = (m == PM_ACTIVE);
            CK_AUX:  r = (m == PM_ACTIVE) || (m == PM_LP0) || (m == PM_LP1) ||
                         (m == PM_LP2)    || (m == PM_LP3);
            CK_SUB:  r = !sub_off &&
                         ((m == PM_ACTIVE) || (m == PM_LP0) || (m == PM_LP1));
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic clock_wanted(gate_cfg_t c, logic req_sync, int idx);
        if (is_retention(c.mode)) begin
            return 1'b0;
        end
        return runs_unrequested(c.mode, c.sub_off, idx) || (c.req_en[idx] && req_sync);
    endfunction

endpackage

// File: rtl/pcg_cfg_reg.sv
module pcg_cfg_reg
    import pcg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [MODE_W-1:0]  mode_in,
    input  logic               sub_off_in,
    input  logic [NUM_CLK-1:0] req_en_in,
    output gate_cfg_t          cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mode    <= PM_ACTIVE;
            cfg_q.sub_off <= 1'b0;
            cfg_q.req_en  <= '0;
        end else begin
            cfg_q.mode    <= pwr_mode_e'(mode_in);
            cfg_q.sub_off <= sub_off_in;
            cfg_q.req_en  <= req_en_in;
        end
    end

endmodule

// File: rtl/pcg_sync.sv
module pcg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/pcg_gate_cell.sv
module pcg_gate_cell (
    input  logic clk_in,
    input  logic en,
    output logic clk_out
);

    logic en_hold;

    // Transparent only while the source clock is low.
    always_latch begin
        if (!clk_in) begin
            en_hold = en;
        end
    end

    assign clk_out = clk_in & en_hold;

endmodule

// File: rtl/pcg_lane.sv
module pcg_lane
    import pcg_pkg::*;
#(
    parameter int IDX         = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk_src,
    input  logic      rst,
    input  gate_cfg_t cfg,
    input  logic      req_async,
    output logic      req_sync,
    output logic      en_q,
    output logic      clk_gated
);

    logic want;

    pcg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk_src),
        .rst     (rst),
        .d_async (req_async),
        .q_sync  (req_sync)
    );

    always_comb begin
        want = clock_wanted(cfg, req_sync, IDX);
    end

    always_ff @(posedge clk_src) begin
        if (rst) begin
            en_q <= 1'b0;
        end else begin
            en_q <= want;
        end
    end

    pcg_gate_cell u_gate (
        .clk_in  (clk_src),
        .en      (en_q),
        .clk_out (clk_gated)
    );

endmodule

// File: rtl/pcg_top.sv
module pcg_top
    import pcg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_ctl,
    input  logic               rst,
    input  logic [NUM_CLK-1:0] clk_src,
    input  logic [MODE_W-1:0]  pwr_mode,
    input  logic               sub_force_off,
    input  logic [NUM_CLK-1:0] req_en,
    input  logic [NUM_CLK-1:0] req,
    output logic [NUM_CLK-1:0] clk_en,
    output logic [NUM_CLK-1:0] clk_gated
);

    gate_cfg_t          cfg_q;
    logic [NUM_CLK-1:0] req_sync;

    pcg_cfg_reg u_cfg (
        .clk        (clk_ctl),
        .rst        (rst),
        .mode_in    (pwr_mode),
        .sub_off_in (sub_force_off),
        .req_en_in  (req_en),
        .cfg_q      (cfg_q)
    );

    for (genvar i = 0; i < NUM_CLK; i++) begin : g_lane
        pcg_lane #(.IDX(i), .SYNC_STAGES(SYNC_STAGES)) u_lane (
            .clk_src   (clk_src[i]),
            .rst       (rst),
            .cfg       (cfg_q),
            .req_async (req[i]),
            .req_sync  (req_sync[i]),
            .en_q      (clk_en[i]),
            .clk_gated (clk_gated[i])
        );
    end

endmodule

// File: rtl/pcg_checker.sv
module pcg_checker
    import pcg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input gate_cfg_t          cfg,
    input logic [NUM_CLK-1:0] req_sync,
    input logic [NUM_CLK-1:0] clk_en
);

    logic ret_mode, lp_mode, aux_on_mode, sub_on_mode;

    assign ret_mode    = (cfg.mode == PM_RET_A) || (cfg.mode == PM_RET_B);
    assign lp_mode     = !ret_mode && (cfg.mode != PM_ACTIVE);
    assign aux_on_mode = (cfg.mode <= PM_LP3);
    assign sub_on_mode = !cfg.sub_off && (cfg.mode <= PM_LP1);

    assert_retention_off_R2: assert property (@(posedge clk) disable iff (rst)
        ret_mode |=> (clk_en == '0));

    assert_main_active_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == PM_ACTIVE) |=> clk_en[CK_MAIN]);

    assert_main_needs_request_R3: assert property (@(posedge clk) disable iff (rst)
        (lp_mode && !req_sync[CK_MAIN]) |=> !clk_en[CK_MAIN]);

    assert_aux_always_on_R4: assert property (@(posedge clk) disable iff (rst)
        aux_on_mode |=> clk_en[CK_AUX]);

    assert_sub_always_on_R5: assert property (@(posedge clk) disable iff (rst)
        sub_on_mode |=> clk_en[CK_SUB]);

    assert_sub_forced_off_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg.sub_off && !req_sync[CK_SUB]) |=> !clk_en[CK_SUB]);

endmodule

bind pcg_top pcg_checker u_chk (
    .clk      (clk_ctl),
    .rst      (rst),
    .cfg      (cfg_q),
    .req_sync (req_sync),
    .clk_en   (clk_en)
);

// File: tb/pcg_top_test.sv
`timescale 1ns/1ps
module pcg_top_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] pwr_mode;
    logic       sub_force_off;
    logic [2:0] req_en;
    logic [2:0] req;
    logic [2:0] clk_en;
    logic [2:0] clk_gated;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    pcg_top uut (
        .clk_ctl       (clk),
        .rst           (rst),
        .clk_src       ({clk, clk, clk}),
        .pwr_mode      (pwr_mode),
        .sub_force_off (sub_force_off),
        .req_en        (req_en),
        .req           (req),
        .clk_en        (clk_en),
        .clk_gated     (clk_gated)
    );

    // {mode[12:10], force[9], req_en[8:6], req[5:3], expected en[2:0]}
    // per-clock bit order: 2 sub-main, 1 main, 0 aux
    localparam int NV = 17;
    localparam logic [12:0] VEC [NV] = '{
        {3'd0, 1'b0, 3'b000, 3'b000, 3'b111},
        {3'd1, 1'b0, 3'b000, 3'b000, 3'b101},
        {3'd1, 1'b0, 3'b010, 3'b010, 3'b111},
        {3'd2, 1'b0, 3'b111, 3'b000, 3'b101},
        {3'd3, 1'b0, 3'b000, 3'b000, 3'b001},
        {3'd3, 1'b0, 3'b100, 3'b100, 3'b101},
        {3'd4, 1'b0, 3'b100, 3'b000, 3'b001},
        {3'd5, 1'b0, 3'b000, 3'b000, 3'b000},
        {3'd5, 1'b0, 3'b001, 3'b001, 3'b001},
        {3'd5, 1'b0, 3'b111, 3'b011, 3'b011},
        {3'd5, 1'b0, 3'b110, 3'b111, 3'b110},
        {3'd0, 1'b1, 3'b000, 3'b000, 3'b011},
        {3'd0, 1'b1, 3'b100, 3'b100, 3'b111},
        {3'd2, 1'b1, 3'b100, 3'b000, 3'b001},
        {3'd6, 1'b0, 3'b111, 3'b111, 3'b000},
        {3'd7, 1'b1, 3'b111, 3'b111, 3'b000},
        {3'd4, 1'b1, 3'b111, 3'b111, 3'b111}
    };

    function automatic string tag_for(logic [2:0] m, logic f, int b);
        if (m >= 3'd6) return "R2";
        if (b == 1)    return "R3";
        if (b == 0)    return "R4";
        if (f)         return "R6";
        return "R5";
    endfunction

    task automatic check3(string tag, string what, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic apply(logic [2:0] m, logic f, logic [2:0] e, logic [2:0] r);
        pwr_mode = m; sub_force_off = f; req_en = e; req = r;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        apply(3'd0, 1'b0, 3'b111, 3'b111);

        // R1: reset state, enables low and gated clocks low in the high phase
        repeat (3) @(posedge clk);
        #1;
        check3("R1", "enable in reset", clk_en, 3'b000);
        check3("R1", "gated in reset", clk_gated, 3'b000);
        @(negedge clk);
        rst = 1'b0;

        // Table walk: R2..R6 and R8
        for (int i = 0; i < NV; i++) begin
            logic [2:0] m, e, r, x;
            logic f;
            {m, f, e, r, x} = VEC[i];
            @(negedge clk);
            apply(m, f, e, r);
            repeat (4) @(posedge clk);
            @(negedge clk);
            #1;
            for (int b = 0; b < 3; b++) begin
                check3(tag_for(m, f, b), $sformatf("vec %0d enable bit %0d", i, b),
                       {2'b00, clk_en[b]}, {2'b00, x[b]});
            end
            check3("R8", $sformatf("vec %0d gated low phase", i), clk_gated, 3'b000);
            @(posedge clk);
            #1;
            check3("R8", $sformatf("vec %0d gated high phase", i), clk_gated, x);
        end

        // R7: request latency through the synchronisers (code 5, all enabled)
        @(negedge clk);
        apply(3'd5, 1'b0, 3'b111, 3'b000);
        repeat (4) @(posedge clk);
        @(negedge clk);
        req = 3'b111;
        repeat (2) @(posedge clk);
        #1;
        check3("R7", "enable after two edges", clk_en, 3'b000);
        @(posedge clk);
        #1;
        check3("R7", "enable after third edge", clk_en, 3'b111);
        // R8: gated clock lags the new enable by one cycle
        check3("R8", "gated same high phase", clk_gated, 3'b000);
        @(posedge clk);
        #1;
        check3("R8", "gated next high phase", clk_gated, 3'b111);

        // R9: configuration latency through the capture register
        @(negedge clk);
        apply(3'd0, 1'b0, 3'b000, 3'b000);
        repeat (4) @(posedge clk);
        @(negedge clk);
        pwr_mode = 3'd5;
        @(posedge clk);
        #1;
        check3("R9", "enable after one edge", clk_en, 3'b111);
        @(posedge clk);
        #1;
        check3("R9", "enable after second edge", clk_en, 3'b000);

        // R1: reset asserted mid-run clears enables
        @(negedge clk);
        apply(3'd0, 1'b0, 3'b000, 3'b000);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check3("R1", "enable after reset edge", clk_en, 3'b000);
        @(posedge clk);
        #1;
        check3("R1", "gated during reset", clk_gated, 3'b000);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule